// File: doc/BRIEF.md
# I2C Read-Only Target with Host-Paced Clock Stretching

This block is the target side of an I2C bus that serves master read transfers. It watches the bus for a Start condition and shifts in the address byte. When the 7-bit address equals its own, it acknowledges on the ninth clock. If the direction bit asks for a read, the block then keeps SCL low until the local host has supplied the next byte. It shifts that byte out most significant bit first, releases SDA so the master can acknowledge, and either stretches again for another byte or drops back to idle.

The host side is small. A write strobe loads an eight-bit transmit buffer and raises a buffer-full flag. A release strobe lets the clock go, but only once the buffer holds a byte. A sticky interrupt flag marks the end of every byte the block serves, and the host clears it with a strobe. Both bus pins are modelled as open-drain: each output only says "pull low" or "let go".

Top module: `i2c_rd_target`

## Requirements
- R1: After reset, the block pulls neither line low, and the buffer-full flag, interrupt flag and read-mode flag are all 0.
- R2: A Start (SDA falling while SCL is high) restarts address reception from any state, including after an ignored address. A Stop (SDA rising while SCL is high) returns the block to idle, and a byte clocked after a Stop without a new Start is not acknowledged.
- R3: The first byte after a Start is taken as the 7-bit address, MSB first, followed by a direction bit in which 1 means read. If the address equals TARGET_ADDR, the block drives SDA low during the 9th clock and sets read_mode_o to the direction bit.
- R4: On an address mismatch, the block does not acknowledge and ignores all further clocks until the next Start. A matching byte sent without a new Start gets no ACK, and the interrupt flag is not set.
- R5: A matching address with the direction bit at 0 is acknowledged with read_mode_o = 0. SCL is not stretched afterwards.
- R6: After a matching read address, from the 9th falling SCL edge the block holds SCL low and sets the interrupt flag.
- R7: A host buffer write sets buf_full_o. A release strobe given while the buffer is full frees SCL. A release strobe given while the buffer is empty is discarded and is not remembered for a later write.
- R8: Data bits leave MSB first, and the block changes SDA only while SCL is low.
- R9: buf_full_o stays 1 through the first seven falling SCL edges of a data byte and clears on the 8th.
- R10: After the 8th falling SCL edge of a data byte, the block releases SDA for the master's acknowledge bit.
- R11: The interrupt flag sets on the 9th falling SCL edge of each served byte and not before. It stays set until the host clears it.
- R12: If the master acknowledges (SDA low on the 9th clock), the block holds SCL low again and needs a fresh buffer write and release before the next byte.
- R13: If the master does not acknowledge, the block releases SCL and returns to idle. It ignores further clocks until a Start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level as seen on the bus |
| sda_i | input | 1 | SDA line level as seen on the bus |
| scl_low_o | output | 1 | 1 = pull SCL low (clock stretch) |
| sda_low_o | output | 1 | 1 = pull SDA low |
| host_wr_i | input | 1 | Host strobe: load transmit buffer |
| host_wdata_i | input | DATA_W | Byte to load into the transmit buffer |
| host_release_i | input | 1 | Host strobe: release the stretched clock |
| host_irq_clr_i | input | 1 | Host strobe: clear the interrupt flag |
| buf_full_o | output | 1 | Transmit buffer holds a byte not yet shifted |
| irq_o | output | 1 | Sticky per-byte interrupt flag |
| read_mode_o | output | 1 | Direction bit of the last matched address |

## Verification
The bench builds the block with TARGET_ADDR = 7'h2A, DATA_W = 8 and SYNC_STAGES = 3. Its bus model runs 16 system clocks per SCL half period. The three-stage synchroniser adds latency between a bus edge and the block's reaction, yet every SDA change must still land inside the SCL low phase. These values therefore test that margin. The neighbouring address 7'h2B and a far address 7'h15 cover mismatches that differ in one bit and in many bits. The data bytes 8'h81 and 8'h5E cover the MSB-first order and the release of SDA after the last bit.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_TX_WAIT,
    ST_TX_SETUP,
    ST_TX_BITS,
    ST_TX_ACK,
    ST_IGNORE
  } tgt_state_e;

  // Upper seven bits of the received address byte against the own address.
  function automatic logic addr_hit(input logic [7:0] rx_byte, input logic [6:0] own_addr);
    return rx_byte[7:1] == own_addr;
  endfunction

  // Inverted bit: 1 means the open-drain output pulls the line low.
  function automatic logic drive_for(input logic bit_val);
    return ~bit_val;
  endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_p;
  logic              sda_p;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff[g] <= 1'b1;
          sda_ff[g] <= 1'b1;
        end else begin
          scl_ff[g] <= scl_i;
          sda_ff[g] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff[g] <= 1'b1;
          sda_ff[g] <= 1'b1;
        end else begin
          scl_ff[g] <= scl_ff[g-1];
          sda_ff[g] <= sda_ff[g-1];
        end
      end
    end
  end

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2c_tgt_host.sv
module i2c_tgt_host #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  input  logic              host_release_i,
  input  logic              host_irq_clr_i,
  input  logic              load_evt,
  input  logic              bf_clr_evt,
  input  logic              irq_set_evt,
  output logic [DATA_W-1:0] tx_byte,
  output logic              buf_full,
  output logic              rel_req,
  output logic              irq
);
  logic [DATA_W-1:0] buf_q;
  logic              full_q;
  logic              rel_q;
  logic              irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      rel_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (host_wr_i) begin
        buf_q  <= host_wdata_i;
        full_q <= 1'b1;
      end else if (bf_clr_evt) begin
        full_q <= 1'b0;
      end
      // A release with no byte in the buffer is dropped, not stored.
      if (load_evt)
        rel_q <= 1'b0;
      else if (host_release_i && full_q)
        rel_q <= 1'b1;
      if (irq_set_evt)
        irq_q <= 1'b1;
      else if (host_irq_clr_i)
        irq_q <= 1'b0;
    end
  end

  assign tx_byte  = buf_q;
  assign buf_full = full_q;
  assign rel_req  = rel_q;
  assign irq      = irq_q;

  assert_bf_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bf_clr_evt && !host_wr_i) |=> !full_q);

  assert_irq_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !host_irq_clr_i) |=> irq_q);

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h2A,
  parameter int         DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              rel_req,
  input  logic              buf_full_i,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              sda_low_o,
  output logic              scl_low_o,
  output logic              read_mode_o,
  output logic              load_evt,
  output logic              bf_clr_evt,
  output logic              irq_set_evt
);
  localparam int              CNT_W     = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  tgt_state_e        state_q;
  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              sda_q;
  logic              scl_q;
  logic              rw_q;
  logic              ack_q;
  logic              bus_evt;

  assign bus_evt     = start_evt | stop_evt;
  assign load_evt    = (state_q == ST_TX_WAIT) && rel_req && !bus_evt;
  assign bf_clr_evt  = (state_q == ST_TX_BITS) && scl_fall && (cnt_q == CNT_LAST) && !bus_evt;
  assign irq_set_evt = scl_fall && !bus_evt &&
                       (((state_q == ST_ADDR_ACK) && rw_q) || (state_q == ST_TX_ACK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
      sda_q   <= 1'b0;
      scl_q   <= 1'b0;
      rw_q    <= 1'b0;
      ack_q   <= 1'b0;
    end else if (start_evt) begin
      state_q <= ST_ADDR;
      sh_q    <= '0;
      cnt_q   <= '0;
      sda_q   <= 1'b0;
      scl_q   <= 1'b0;
      rw_q    <= 1'b0;
    end else if (stop_evt) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sda_q   <= 1'b0;
      scl_q   <= 1'b0;
      rw_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise) begin
            sh_q  <= {sh_q[DATA_W-2:0], sda_s};
            cnt_q <= cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            cnt_q <= '0;
            if (addr_hit(sh_q[7:0], TARGET_ADDR)) begin
              sda_q   <= 1'b1;
              rw_q    <= sh_q[0];
              state_q <= ST_ADDR_ACK;
            end else begin
              state_q <= ST_IGNORE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            sda_q <= 1'b0;
            if (rw_q) begin
              scl_q   <= 1'b1;
              state_q <= ST_TX_WAIT;
            end else begin
              state_q <= ST_IGNORE;
            end
          end
        end
        ST_TX_WAIT: begin
          if (rel_req) begin
            sh_q    <= tx_byte;
            sda_q   <= drive_for(tx_byte[DATA_W-1]);
            cnt_q   <= '0;
            state_q <= ST_TX_SETUP;
          end
        end
        ST_TX_SETUP: begin
          // SDA settled one cycle earlier; now let the clock go.
          scl_q   <= 1'b0;
          state_q <= ST_TX_BITS;
        end
        ST_TX_BITS: begin
          if (scl_fall) begin
            if (cnt_q == CNT_LAST) begin
              sda_q   <= 1'b0;
              cnt_q   <= '0;
              state_q <= ST_TX_ACK;
            end else begin
              cnt_q <= cnt_q + 1'b1;
              sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
              sda_q <= drive_for(sh_q[DATA_W-2]);
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            ack_q <= ~sda_s;
          end else if (scl_fall) begin
            if (ack_q) begin
              scl_q   <= 1'b1;
              state_q <= ST_TX_WAIT;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_low_o   = sda_q;
  assign scl_low_o   = scl_q;
  assign read_mode_o = rw_q;

  assert_sda_moves_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(sda_q) != sda_q) && !$past(bus_evt)) |-> !$past(scl_s));

  assert_load_needs_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> buf_full_i);

  assert_start_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state_q == ST_ADDR));

  assert_hold_when_waiting_R6: assert property (@(posedge clk) disable iff (!rst_n)
    scl_q |-> (state_q == ST_TX_WAIT || state_q == ST_TX_SETUP));

  assert_nack_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_TX_ACK) && scl_fall && !ack_q && !bus_evt) |=> (state_q == ST_IDLE && !scl_q));

endmodule

// File: rtl/i2c_rd_target.sv
module i2c_rd_target #(
  parameter logic [6:0] TARGET_ADDR = 7'h2A,
  parameter int         DATA_W      = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_low_o,
  output logic              sda_low_o,
  input  logic              host_wr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  input  logic              host_release_i,
  input  logic              host_irq_clr_i,
  output logic              buf_full_o,
  output logic              irq_o,
  output logic              read_mode_o
);
  logic              scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic              rel_req, load_evt, bf_clr_evt, irq_set_evt;
  logic [DATA_W-1:0] tx_byte;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  i2c_tgt_host #(.DATA_W(DATA_W)) u_host (
    .clk            (clk),
    .rst_n          (rst_n),
    .host_wr_i      (host_wr_i),
    .host_wdata_i   (host_wdata_i),
    .host_release_i (host_release_i),
    .host_irq_clr_i (host_irq_clr_i),
    .load_evt       (load_evt),
    .bf_clr_evt     (bf_clr_evt),
    .irq_set_evt    (irq_set_evt),
    .tx_byte        (tx_byte),
    .buf_full       (buf_full_o),
    .rel_req        (rel_req),
    .irq            (irq_o)
  );

  i2c_tgt_fsm #(.TARGET_ADDR(TARGET_ADDR), .DATA_W(DATA_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_s       (scl_s),
    .sda_s       (sda_s),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_evt   (start_evt),
    .stop_evt    (stop_evt),
    .rel_req     (rel_req),
    .buf_full_i  (buf_full_o),
    .tx_byte     (tx_byte),
    .sda_low_o   (sda_low_o),
    .scl_low_o   (scl_low_o),
    .read_mode_o (read_mode_o),
    .load_evt    (load_evt),
    .bf_clr_evt  (bf_clr_evt),
    .irq_set_evt (irq_set_evt)
  );

endmodule

// File: tb/i2c_rd_target_bench.sv
`timescale 1ns/1ps
module i2c_rd_target_bench;
  localparam int         HALF = 16;
  localparam logic [6:0] OWN  = 7'h2A;
  localparam int         NVEC = 5;
  // Fields: [16:10] address, [9] direction, [8:1] data byte, [0] expect ACK
  localparam logic [16:0] VEC [NVEC] = '{
    {7'h2A, 1'b1, 8'hA5, 1'b1},
    {7'h2A, 1'b1, 8'h3C, 1'b1},
    {7'h15, 1'b1, 8'h00, 1'b0},
    {7'h2A, 1'b0, 8'h00, 1'b1},
    {7'h2B, 1'b1, 8'hFF, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic host_wr = 1'b0, host_rel = 1'b0, host_clr = 1'b0;
  logic [7:0] host_data = '0;
  logic scl_low, sda_low, buf_full, irq, read_mode;
  logic scl_line, sda_line;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign scl_line = m_scl & ~scl_low;
  assign sda_line = m_sda & ~sda_low;

  i2c_rd_target #(.TARGET_ADDR(OWN), .DATA_W(8), .SYNC_STAGES(3)) u_i2c_rd_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_low_o(scl_low), .sda_low_o(sda_low),
    .host_wr_i(host_wr), .host_wdata_i(host_data), .host_release_i(host_rel),
    .host_irq_clr_i(host_clr), .buf_full_o(buf_full), .irq_o(irq), .read_mode_o(read_mode));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (!scl_line) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; idle(HALF);
    m_scl = 1'b1; wait_scl_high(); idle(HALF);
    m_sda = 1'b0; idle(HALF);
    m_scl = 1'b0; idle(HALF);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; idle(HALF);
    m_scl = 1'b1; wait_scl_high(); idle(HALF);
    m_sda = 1'b1; idle(HALF);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; idle(HALF);
    m_scl = 1'b1; wait_scl_high(); idle(HALF);
    m_scl = 1'b0; idle(HALF);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; idle(HALF);
    m_scl = 1'b1; wait_scl_high(); idle(HALF / 2);
    b = sda_line; idle(HALF / 2);
    m_scl = 1'b0; idle(HALF);
  endtask

  task automatic put_byte(input logic [7:0] v);
    for (int k = 7; k >= 0; k--) put_bit(v[k]);
  endtask

  task automatic get_byte(output logic [7:0] v);
    logic b;
    for (int k = 7; k >= 0; k--) begin
      get_bit(b);
      v[k] = b;
    end
  endtask

  task automatic pulse_wr(input logic [7:0] d);
    host_data = d; host_wr = 1'b1; @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic pulse_rel();
    host_rel = 1'b1; @(negedge clk); host_rel = 1'b0;
  endtask

  task automatic pulse_clr();
    host_clr = 1'b1; @(negedge clk); host_clr = 1'b0;
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic       ackb;
    logic [7:0] rx;
    idle(5);
    rst_n = 1'b1;
    idle(4);
    // R1: reset state
    check("R1 scl_low", scl_low, 0);
    check("R1 sda_low", sda_low, 0);
    check("R1 buf_full", buf_full, 0);
    check("R1 irq", irq, 0);
    check("R1 read_mode", read_mode, 0);

    // Table of transactions
    for (int i = 0; i < NVEC; i++) begin
      logic [6:0] a;
      logic       rw, exp_ack;
      logic [7:0] d;
      {a, rw, d, exp_ack} = VEC[i];
      bus_start();
      put_byte({a, rw});
      get_bit(ackb);
      if (exp_ack) begin
        check("R3 address ACK", ackb, 0);
        check("R3 read_mode", read_mode, rw);
      end else begin
        check("R4 no ACK on mismatch", ackb, 1);
      end
      if (exp_ack && rw) begin
        check("R6 SCL held", scl_low, 1);
        check("R6 irq set", irq, 1);
        pulse_clr();
        pulse_wr(d);
        pulse_rel();
        idle(6);
        check("R7 SCL released", scl_low, 0);
        get_byte(rx);
        check("R8 data MSB first", rx, d);
        put_bit(1'b1);
        idle(4);
        check("R13 SCL free after NACK", scl_low, 0);
        check("R13 SDA free after NACK", sda_low, 0);
        pulse_clr();
      end else begin
        idle(4);
        check(rw ? "R4 no stretch" : "R5 no stretch", scl_low, 0);
        check(rw ? "R4 irq clear" : "R5 irq clear", irq, 0);
      end
      bus_stop();
    end

    // Directed: empty release, buffer-full timing, ACK continuation, NACK end
    bus_start();
    put_byte({OWN, 1'b1});
    get_bit(ackb);
    check("R3 ACK", ackb, 0);
    check("R11 irq after address", irq, 1);
    pulse_clr();
    check("R11 irq cleared by host", irq, 0);
    pulse_rel();
    idle(8);
    check("R7 release on empty ignored", scl_low, 1);
    check("R7 buffer empty", buf_full, 0);
    pulse_wr(8'h81);
    check("R7 write sets buf_full", buf_full, 1);
    idle(8);
    check("R7 dropped release not stored", scl_low, 1);
    pulse_rel();
    idle(6);
    check("R7 release after write", scl_low, 0);
    for (int k = 7; k >= 1; k--) begin
      get_bit(ackb);
      rx[k] = ackb;
    end
    check("R9 buf_full after 7 falls", buf_full, 1);
    check("R11 irq not before 9th", irq, 0);
    get_bit(ackb);
    rx[0] = ackb;
    check("R9 buf_full clear at 8th fall", buf_full, 0);
    check("R11 irq not at 8th", irq, 0);
    check("R8 byte 81", rx, 8'h81);
    check("R10 SDA released", sda_low, 0);
    put_bit(1'b0);
    idle(2);
    check("R11 irq at 9th fall", irq, 1);
    check("R12 SCL held again", scl_low, 1);
    idle(20);
    check("R11 irq sticky", irq, 1);
    check("R12 still held without new load", scl_low, 1);
    pulse_clr();
    pulse_wr(8'h5E);
    pulse_rel();
    get_byte(rx);
    check("R12 second byte", rx, 8'h5E);
    put_bit(1'b1);
    idle(4);
    check("R13 idle after NACK", scl_low, 0);
    check("R11 irq after NACKed byte", irq, 1);
    pulse_clr();
    put_byte({OWN, 1'b1});
    get_bit(ackb);
    check("R13 clocks ignored after NACK", ackb, 1);
    check("R13 no stretch", scl_low, 0);
    bus_stop();

    // Directed: ignore after mismatch, then repeated start
    bus_start();
    put_byte({7'h15, 1'b1});
    get_bit(ackb);
    check("R4 mismatch", ackb, 1);
    put_byte({OWN, 1'b1});
    get_bit(ackb);
    check("R4 ignored until Start", ackb, 1);
    check("R4 irq unchanged", irq, 0);
    bus_start();
    put_byte({OWN, 1'b0});
    get_bit(ackb);
    check("R2 repeated start ACK", ackb, 0);
    check("R5 read_mode 0", read_mode, 0);
    idle(4);
    check("R5 no stretch on write", scl_low, 0);
    bus_stop();
    m_sda = 1'b1; idle(HALF);
    m_scl = 1'b0; idle(HALF);
    put_byte({OWN, 1'b1});
    get_bit(ackb);
    check("R2 stop returns idle", ackb, 1);
    bus_stop();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule